// File: doc/BRIEF.md
# Telemetry Data Block Assembler

This block assembles fixed-length recorder data blocks made of 24-bit words. Each block opens with an eight-word session header that the block builds itself from configuration inputs, the externally supplied BCD date and time words and an internal running block number. The channel packets follow. An upstream packet source provides them over a valid/ready stream, one packet per active channel in ascending logical channel order. Each packet is delimited by a last flag. Once the final active channel's packet has passed, the block pads with all-ones words up to word 2047.

Output is a word strobe with a 24-bit word, the word's index within the block and a pulse on the first word. The upstream source is held off while header or fill words go out and while the block is idle. When the packets of a block do not fit, the packet that crosses word 2047 is cut at the block boundary. Its remaining words, and any later packets of that block, are taken from the upstream source and discarded. A per-channel overflow mask is then presented for the source to place into its packet headers in the following block.

Top module: `tlm_block_asm`

## Requirements
- R1: Every block consists of exactly 2048 output strobes with indices 0, 1, ..., 2047 in order. `out_sob` is high on the strobe with index 0 and on no other strobe.
- R2: Header word 0 is 0x36E19C. Word 1 holds the sync remainder 5'b01001 in bits 23:19 and the 19-bit master clock value in bits 18:0.
- R3: Header word 2 carries the block number. It is 0 in the first block after `run` is raised. It increases by one, modulo 2^24, with each completed block. It returns to 0 whenever the block sits idle with `run` low, and no block starts while `run` is low.
- R4: Header word 3 is the date word, word 4 is the time word and word 5 is the 24-bit block marker divisor.
- R5: Header word 6 is {clock-source flag, channel count minus one [3:0], 2'b00, start second [16:0]}. Header word 7 is {user byte [7:0], 10'b0, version [5:0]}.
- R6: All header inputs, including the channel count, are sampled once at the start of a block. A change made while the block is being emitted first shows in the following block.
- R7: Starting at word 8, packet words are passed through unchanged, in arrival order, for channels 0 up to the configured count minus one. Each packet holds at least one word and ends at the word flagged last.
- R8: Every word after the last word of the final channel's packet is 0xFFFFFF, up to and including word 2047.
- R9: `pkt_ready` is low while header words are emitted, while fill words are emitted and while idle. No output strobe occurs in the packet phase without an upstream transfer.
- R10: When packet data would extend past word 2047, the block ends at word 2047. The rest of the cut packet, and every later packet of that block, is accepted and discarded with no output strobe. Then the next block starts.
- R11: `prev_ovr` bit n is 1 when channel n's packet was cut or dropped in the block just finished. A packet that ends exactly on word 2047 does not count. The mask is valid from the first word of the next block and is cleared together with the block number while idle with `run` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level enable; a new block starts only while high |
| cfg_mclk | input | 19 | Master clock value, 250 Hz units |
| cfg_bmd | input | 24 | Block marker divisor |
| cfg_int_clk | input | 1 | Master clock source flag, 1 = internal |
| cfg_nchan_m1 | input | 4 | Number of active channels minus one |
| cfg_start_sec | input | 17 | Session start second of day |
| cfg_user | input | 8 | User-defined byte |
| cfg_version | input | 6 | Format version |
| tc_date | input | 24 | BCD date word |
| tc_time | input | 24 | BCD time word |
| pkt_data | input | 24 | Packet word from upstream |
| pkt_valid | input | 1 | Upstream word valid |
| pkt_last | input | 1 | Word is the last of its packet |
| pkt_ready | output | 1 | Block accepts an upstream word |
| out_word | output | 24 | Output word |
| out_valid | output | 1 | Output word strobe |
| out_index | output | 11 | Index of the word within its block |
| out_sob | output | 1 | First word of a block |
| prev_ovr | output | 16 | Per-channel overflow mask of the previous block |

## Verification
The assertions assume that the upstream source keeps to the packet discipline: data and the last flag are stable while offered, every packet has at least one word, and exactly as many packets arrive per block as the sampled channel count calls for. The stimulus builds each block's packet list from the channel count it sets before that block starts. It offers words strictly in order with random idle gaps, advances only on cycles where ready was seen high, and never offers a packet beyond the configured count. Packet lengths are chosen so that they fit with room for fill, fit exactly, or overrun the block.

// File: rtl/tlm_blk_pkg.sv
package tlm_blk_pkg;

    localparam int WORD_W    = 24;
    localparam int HDR_WORDS = 8;
    localparam int CHAN_MAX  = 16;
    localparam int CH_W      = $clog2(CHAN_MAX);
    localparam int BLKNUM_W  = 24;

    localparam logic [WORD_W-1:0] SYNC_LOW  = 24'h36E19C;
    localparam logic [4:0]        SYNC_HIGH = 5'b01001;
    localparam logic [WORD_W-1:0] FILL_WORD = '1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_PKT,
        PH_FILL,
        PH_DRAIN
    } phase_e;

    typedef enum logic [1:0] {
        SRC_HDR,
        SRC_PKT,
        SRC_FILL
    } word_src_e;

    typedef struct packed {
        logic [18:0]     mclk;
        logic [23:0]     bmd;
        logic            int_clk;
        logic [CH_W-1:0] nch_m1;
        logic [16:0]     start_sec;
        logic [7:0]      user;
        logic [5:0]      version;
        logic [23:0]     date;
        logic [23:0]     tod;
    } sess_cfg_t;

    function automatic logic [WORD_W-1:0] header_word(
        input sess_cfg_t             c,
        input logic [BLKNUM_W-1:0]   blk,
        input logic [2:0]            sel
    );
        logic [WORD_W-1:0] w;
        unique case (sel)
            3'd0: w = SYNC_LOW;
            3'd1: w = {SYNC_HIGH, c.mclk};
            3'd2: w = blk;
            3'd3: w = c.date;
            3'd4: w = c.tod;
            3'd5: w = c.bmd;
            3'd6: w = {c.int_clk, c.nch_m1, 2'b00, c.start_sec};
            default: w = {c.user, 10'b0, c.version};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tlm_blk_hdr.sv
module tlm_blk_hdr
    import tlm_blk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  sess_cfg_t             cfg_in,
    input  logic [BLKNUM_W-1:0]   blk_num,
    input  logic [2:0]            sel,
    output logic [WORD_W-1:0]     hdr_word,
    output logic [CH_W-1:0]       nch_m1
);

    sess_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        hdr_word = header_word(cfg_q, blk_num, sel);
        nch_m1   = cfg_q.nch_m1;
    end

    // Held configuration only moves on a capture (R6)
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> cfg_q == $past(cfg_q));

endmodule

// File: rtl/tlm_blk_seq.sv
module tlm_blk_seq
    import tlm_blk_pkg::*;
#(
    parameter int BLOCK_WORDS = 2048,
    parameter int IDX_W       = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pkt_valid,
    input  logic             pkt_last,
    input  logic [CH_W-1:0]  nch_m1,
    output logic             pkt_ready,
    output logic             emit,
    output word_src_e        src,
    output logic [IDX_W-1:0] widx,
    output logic             capture,
    output logic             idle_clear,
    output logic             blk_end,
    output logic             ovr_hit,
    output logic [CH_W-1:0]  ovr_from
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_WORDS - 1);
    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_WORDS - 1);

    phase_e          state;
    logic [CH_W-1:0] chan;
    logic            xfer;
    logic            at_last;
    logic            final_pkt;

    always_comb begin
        pkt_ready  = (state == PH_PKT) || (state == PH_DRAIN);
        xfer       = pkt_valid && pkt_ready;
        at_last    = (widx == LAST_IDX);
        final_pkt  = (chan == nch_m1);
        emit       = 1'b0;
        src        = SRC_FILL;
        unique case (state)
            PH_HDR:  begin emit = 1'b1; src = SRC_HDR; end
            PH_PKT:  begin emit = xfer; src = SRC_PKT; end
            PH_FILL: begin emit = 1'b1; src = SRC_FILL; end
            default: ;
        endcase
        capture    = (state == PH_IDLE) && run;
        idle_clear = (state == PH_IDLE) && !run;
        blk_end    = emit && at_last;
        ovr_hit    = (state == PH_PKT) && xfer && at_last && !(pkt_last && final_pkt);
        ovr_from   = pkt_last ? chan + 1'b1 : chan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            widx  <= '0;
            chan  <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (run) begin
                        state <= PH_HDR;
                        widx  <= '0;
                    end
                end
                PH_HDR: begin
                    widx <= widx + 1'b1;
                    if (widx == HDR_END) begin
                        state <= PH_PKT;
                        chan  <= '0;
                    end
                end
                PH_PKT: begin
                    if (xfer) begin
                        if (at_last) begin
                            if (ovr_hit) begin
                                state <= PH_DRAIN;
                                chan  <= ovr_from;
                            end else begin
                                state <= PH_IDLE;
                            end
                        end else begin
                            widx <= widx + 1'b1;
                            if (pkt_last) begin
                                if (final_pkt) state <= PH_FILL;
                                else           chan  <= chan + 1'b1;
                            end
                        end
                    end
                end
                PH_FILL: begin
                    if (at_last) state <= PH_IDLE;
                    else         widx  <= widx + 1'b1;
                end
                PH_DRAIN: begin
                    if (xfer && pkt_last) begin
                        if (final_pkt) state <= PH_IDLE;
                        else           chan  <= chan + 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // After the final word of a block nothing more is emitted for it (R1)
    assert_block_close_R1: assert property (@(posedge clk) disable iff (rst)
        blk_end |=> (state == PH_IDLE || state == PH_DRAIN));

    // A block always starts from index zero in the header phase (R1)
    assert_block_open_R1: assert property (@(posedge clk) disable iff (rst)
        capture |=> (state == PH_HDR && widx == '0));

    // Draining only ever follows a cut at the block boundary (R10)
    assert_drain_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_DRAIN && $past(state) != PH_DRAIN) |-> $past(ovr_hit));

endmodule

// File: rtl/tlm_blk_ovr.sv
module tlm_blk_ovr
    import tlm_blk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                idle_clear,
    input  logic                blk_end,
    input  logic                ovr_hit,
    input  logic [CH_W-1:0]     ovr_from,
    input  logic [CH_W-1:0]     nch_m1,
    output logic [BLKNUM_W-1:0] blk_num,
    output logic [CHAN_MAX-1:0] prev_ovr
);

    logic [CHAN_MAX-1:0] hit_mask;

    generate
        for (genvar n = 0; n < CHAN_MAX; n++) begin : g_mask
            assign hit_mask[n] = ovr_hit
                              && (CH_W'(n) >= ovr_from)
                              && (CH_W'(n) <= nch_m1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || idle_clear) begin
            blk_num  <= '0;
            prev_ovr <= '0;
        end else if (blk_end) begin
            blk_num  <= blk_num + 1'b1;
            prev_ovr <= hit_mask;
        end
    end

    // Block number steps by exactly one per completed block (R3)
    assert_blk_step_R3: assert property (@(posedge clk) disable iff (rst)
        (blk_end && !idle_clear) |=> blk_num == $past(blk_num) + 1'b1);

    // A clean block leaves an empty overflow mask (R11)
    assert_clean_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (blk_end && !ovr_hit) |=> prev_ovr == '0);

    // The cut channel itself is always flagged (R11)
    assert_cut_flagged_R11: assert property (@(posedge clk) disable iff (rst)
        (ovr_hit && ovr_from <= nch_m1) |=> $countones(prev_ovr) != 0);

endmodule

// File: rtl/tlm_block_asm.sv
module tlm_block_asm
    import tlm_blk_pkg::*;
#(
    parameter  int BLOCK_WORDS = 2048,
    localparam int IDX_W       = $clog2(BLOCK_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [18:0]         cfg_mclk,
    input  logic [23:0]         cfg_bmd,
    input  logic                cfg_int_clk,
    input  logic [3:0]          cfg_nchan_m1,
    input  logic [16:0]         cfg_start_sec,
    input  logic [7:0]          cfg_user,
    input  logic [5:0]          cfg_version,
    input  logic [23:0]         tc_date,
    input  logic [23:0]         tc_time,
    input  logic [23:0]         pkt_data,
    input  logic                pkt_valid,
    input  logic                pkt_last,
    output logic                pkt_ready,
    output logic [23:0]         out_word,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_index,
    output logic                out_sob,
    output logic [15:0]         prev_ovr
);

    localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(HDR_WORDS);

    sess_cfg_t            cfg_in;
    logic                 emit;
    word_src_e            src;
    logic [IDX_W-1:0]     widx;
    logic                 capture;
    logic                 idle_clear;
    logic                 blk_end;
    logic                 ovr_hit;
    logic [CH_W-1:0]      ovr_from;
    logic [CH_W-1:0]      nch_m1;
    logic [BLKNUM_W-1:0]  blk_num;
    logic [WORD_W-1:0]    hdr_word;

    always_comb begin
        cfg_in.mclk      = cfg_mclk;
        cfg_in.bmd       = cfg_bmd;
        cfg_in.int_clk   = cfg_int_clk;
        cfg_in.nch_m1    = cfg_nchan_m1;
        cfg_in.start_sec = cfg_start_sec;
        cfg_in.user      = cfg_user;
        cfg_in.version   = cfg_version;
        cfg_in.date      = tc_date;
        cfg_in.tod       = tc_time;
    end

    tlm_blk_hdr u_hdr (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .cfg_in   (cfg_in),
        .blk_num  (blk_num),
        .sel      (widx[2:0]),
        .hdr_word (hdr_word),
        .nch_m1   (nch_m1)
    );

    tlm_blk_seq #(
        .BLOCK_WORDS (BLOCK_WORDS),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .pkt_valid  (pkt_valid),
        .pkt_last   (pkt_last),
        .nch_m1     (nch_m1),
        .pkt_ready  (pkt_ready),
        .emit       (emit),
        .src        (src),
        .widx       (widx),
        .capture    (capture),
        .idle_clear (idle_clear),
        .blk_end    (blk_end),
        .ovr_hit    (ovr_hit),
        .ovr_from   (ovr_from)
    );

    tlm_blk_ovr u_ovr (
        .clk        (clk),
        .rst        (rst),
        .idle_clear (idle_clear),
        .blk_end    (blk_end),
        .ovr_hit    (ovr_hit),
        .ovr_from   (ovr_from),
        .nch_m1     (nch_m1),
        .blk_num    (blk_num),
        .prev_ovr   (prev_ovr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sob   <= 1'b0;
            out_index <= '0;
            out_word  <= '0;
        end else begin
            out_valid <= emit;
            out_sob   <= emit && (widx == '0);
            if (emit) begin
                out_index <= widx;
                unique case (src)
                    SRC_HDR: out_word <= hdr_word;
                    SRC_PKT: out_word <= pkt_data;
                    default: out_word <= FILL_WORD;
                endcase
            end
        end
    end

    // First word of every block carries the low sync pattern (R2)
    assert_sync_low_R2: assert property (@(posedge clk) disable iff (rst)
        out_sob |-> (out_valid && out_index == '0 && out_word == SYNC_LOW));

    // Upstream words reach the output unchanged (R7)
    assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(pkt_valid && pkt_ready)) |-> out_word == $past(pkt_data));

    // No upstream acceptance while header words go out (R9)
    assert_hdr_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index < HDR_IDX) |-> !$past(pkt_ready));

    // Words emitted past the header without a transfer are fill (R8)
    assert_fill_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index >= HDR_IDX && !$past(pkt_ready)) |-> out_word == FILL_WORD);

    // The last index of a block is never followed directly by another word (R1)
    assert_gap_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index == IDX_W'(BLOCK_WORDS - 1)) |=> !out_valid);

endmodule

// File: tb/tlm_block_asm_test.sv
module tlm_block_asm_test;

    localparam int BLK  = 2048;
    localparam int IDXW = 11;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, run;
    logic [18:0] cfg_mclk;
    logic [23:0] cfg_bmd;
    logic        cfg_int_clk;
    logic [3:0]  cfg_nchan_m1;
    logic [16:0] cfg_start_sec;
    logic [7:0]  cfg_user;
    logic [5:0]  cfg_version;
    logic [23:0] tc_date, tc_time;
    logic [23:0] pkt_data;
    logic        pkt_valid, pkt_last, pkt_ready;
    logic [23:0] out_word;
    logic        out_valid, out_sob;
    logic [IDXW-1:0] out_index;
    logic [15:0] prev_ovr;

    tlm_block_asm uut (
        .clk(clk), .rst(rst), .run(run),
        .cfg_mclk(cfg_mclk), .cfg_bmd(cfg_bmd), .cfg_int_clk(cfg_int_clk),
        .cfg_nchan_m1(cfg_nchan_m1), .cfg_start_sec(cfg_start_sec),
        .cfg_user(cfg_user), .cfg_version(cfg_version),
        .tc_date(tc_date), .tc_time(tc_time),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_last(pkt_last),
        .pkt_ready(pkt_ready), .out_word(out_word), .out_valid(out_valid),
        .out_index(out_index), .out_sob(out_sob), .prev_ovr(prev_ovr)
    );

    int checks = 0;
    int fails  = 0;

    logic [23:0] exp_w [BLK];
    logic [23:0] pq [$];
    bit          lq [$];
    logic [15:0] exp_prev;
    logic [23:0] exp_blk;
    bit          in_cfg_test;

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [23:0] ref_hdr(input int k);
        case (k)
            0: return 24'h36E19C;
            1: return {5'b01001, cfg_mclk};
            2: return exp_blk;
            3: return tc_date;
            4: return tc_time;
            5: return cfg_bmd;
            6: return {cfg_int_clk, cfg_nchan_m1, 2'b00, cfg_start_sec};
            default: return {cfg_user, 10'd0, cfg_version};
        endcase
    endfunction

    function automatic string req_of(input int k);
        if (in_cfg_test && k < 8) return "R6 header sampled at block start";
        if (k < 2)  return "R2 sync/master clock";
        if (k == 2) return "R3 block number";
        if (k < 6)  return "R4 date/time/divisor";
        if (k < 8)  return "R5 packed header word";
        return "R7/R8 payload or fill";
    endfunction

    task automatic build(input int n, input int lens[16], output logic [15:0] mask);
        int pos = 8;
        pq.delete();
        lq.delete();
        mask = '0;
        for (int k = 0; k < 8; k++) exp_w[k] = ref_hdr(k);
        for (int ch = 0; ch < n; ch++) begin
            for (int i = 0; i < lens[ch]; i++) begin
                logic [23:0] d = 24'($urandom);
                pq.push_back(d);
                lq.push_back(i == lens[ch] - 1);
                if (pos < BLK) begin
                    exp_w[pos] = d;
                    pos++;
                end else begin
                    mask[ch] = 1'b1;
                end
            end
        end
        for (int k = pos; k < BLK; k++) exp_w[k] = 24'hFFFFFF;
    endtask

    task automatic run_blk(input int n, input int lens[16], input int gap_pct, input bit cfg_change);
        logic [15:0] nm;
        int count = 0;
        int pos = 0;
        bit prev_rdy = 1'b0;
        cfg_nchan_m1 = 4'(n - 1);
        in_cfg_test = cfg_change;
        build(n, lens, nm);
        while (!(count == BLK && pos == pq.size())) begin
            @(negedge clk);
            if (out_valid) begin
                if (count >= BLK) begin
                    chk(1'b0, "R10 strobe during discard", out_word, 24'h0);
                end else begin
                    chk(out_index == IDXW'(count), "R1 word index", 24'(out_index), 24'(count));
                    chk(out_sob == (count == 0), "R1 start-of-block pulse", 24'(out_sob), 24'(count == 0));
                    if (count == 0)
                        chk(prev_ovr == exp_prev, "R11 previous overflow mask", 24'(prev_ovr), 24'(exp_prev));
                    if (count < 8)
                        chk(!prev_rdy, "R9 ready low during header", 24'(prev_rdy), 24'h0);
                    if (count >= 8 && exp_w[count] == 24'hFFFFFF && pos == pq.size())
                        chk(!prev_rdy, "R9 ready low during fill", 24'(prev_rdy), 24'h0);
                    chk(out_word == exp_w[count], req_of(count), out_word, exp_w[count]);
                    count++;
                end
            end
            if (cfg_change && count == 3) begin
                cfg_mclk      = ~cfg_mclk;
                cfg_bmd       = cfg_bmd + 24'd77;
                cfg_user      = ~cfg_user;
                cfg_version   = cfg_version + 6'd1;
                cfg_start_sec = cfg_start_sec + 17'd9;
                tc_time       = 24'h235959;
            end
            prev_rdy = pkt_ready;
            if (pos < pq.size() && ($urandom % 100) >= gap_pct) begin
                pkt_valid = 1'b1;
                pkt_data  = pq[pos];
                pkt_last  = lq[pos];
                if (pkt_ready) pos++;
            end else begin
                pkt_valid = 1'b0;
                pkt_data  = 24'h0;
                pkt_last  = 1'b0;
            end
        end
        exp_prev = nm;
        exp_blk  = exp_blk + 24'd1;
        in_cfg_test = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int lens[16];
        void'($urandom(32'd5150));
        rst = 1'b1; run = 1'b0;
        cfg_mclk = 19'h4B000; cfg_bmd = 24'h000123; cfg_int_clk = 1'b1;
        cfg_nchan_m1 = 4'd0; cfg_start_sec = 17'd43210; cfg_user = 8'hA5;
        cfg_version = 6'd3; tc_date = 24'h250614; tc_time = 24'h120000;
        pkt_data = '0; pkt_valid = 1'b0; pkt_last = 1'b0;
        exp_prev = '0; exp_blk = '0; in_cfg_test = 1'b0;
        repeat (4) @(negedge clk);
        chk(!out_valid, "R1 no strobe in reset", 24'(out_valid), 24'h0);
        chk(!pkt_ready, "R9 ready low in reset", 24'(pkt_ready), 24'h0);
        chk(prev_ovr == '0, "R11 mask clear in reset", 24'(prev_ovr), 24'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R3 no block while run low", 24'(out_valid), 24'h0);
        run = 1'b1;

        // single short packet, long fill (R8)
        lens = '{default: 0}; lens[0] = 5;
        run_blk(1, lens, 0, 1'b0);
        // four channels with gaps (R7)
        cfg_int_clk = 1'b0; tc_time = 24'h120001;
        foreach (lens[i]) lens[i] = (i < 4) ? 1 + int'($urandom % 200) : 0;
        run_blk(4, lens, 30, 1'b0);
        // all sixteen channels
        foreach (lens[i]) lens[i] = 1 + int'($urandom % 100);
        run_blk(16, lens, 20, 1'b0);
        // overrun: channel 1 cut, channel 2 dropped (R10)
        lens = '{default: 0}; lens[0] = 1500; lens[1] = 600; lens[2] = 100;
        run_blk(3, lens, 25, 1'b0);
        // exact fit, mask from overrun block visible (R11)
        lens = '{default: 0}; lens[0] = 1000; lens[1] = 1040;
        run_blk(2, lens, 10, 1'b0);
        // exact fit then an extra packet that is dropped (R10)
        lens = '{default: 0}; lens[0] = 2040; lens[1] = 10;
        run_blk(2, lens, 10, 1'b0);
        // stop and restart: counters cleared (R3, R11)
        run = 1'b0;
        repeat (6) @(negedge clk);
        chk(!out_valid, "R3 idle while run low", 24'(out_valid), 24'h0);
        chk(prev_ovr == '0, "R11 mask cleared while idle", 24'(prev_ovr), 24'h0);
        exp_blk = '0; exp_prev = '0;
        run = 1'b1;
        // header inputs change mid-header (R6)
        lens = '{default: 0}; lens[0] = 50; lens[1] = 60;
        run_blk(2, lens, 0, 1'b1);
        run_blk(2, lens, 0, 1'b0);
        // random blocks
        for (int b = 0; b < 3; b++) begin
            int n = 1 + int'($urandom % 16);
            cfg_mclk = 19'($urandom); cfg_bmd = 24'($urandom);
            cfg_user = 8'($urandom); tc_date = 24'h250615;
            foreach (lens[i]) lens[i] = (i < n) ? 1 + int'($urandom % (2300 / n)) : 0;
            run_blk(n, lens, 15, 1'b0);
        end
        summary();
        $finish;
    end

endmodule